// File: doc/BRIEF.md
# Banked GPIO Set/Clear Controller

This block is a memory-mapped general-purpose I/O controller for up to 128 pads. The pads are grouped into 64-bit banks. Software changes output levels only through two strobe registers per bank. A 1 written to the set register raises the matching output latch, and a 1 written to the clear register lowers it. Zero bits leave their latches as they are. The settled pad levels are read from a receive register in each bank.

Every pad has its own configuration word. The word holds an output enable, a polarity inverter and an open-drain selector. It also holds a function selector that decides whether the GPIO logic or an alternate on-chip function owns the pad. The inverter acts on both paths: it is applied to the value driven onto the pad and to the value sampled from it. A constant register reports the pad count and a base interrupt vector index. The register bus is a single-cycle write port, and its read data is registered.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset, all output latches and configuration words are 0. Every pad is undriven (`pad_oe` = 0, `pad_out` = 0), and the latch and configuration readbacks return 0.
- R2: A write to the set register raises each latch whose data bit is 1 and leaves the other latches unchanged. Bank 0 uses byte address 0x8. Reading that address returns the current latches.
- R3: A write to the clear register at 0x10 lowers each latch whose data bit is 1 and leaves the other latches unchanged.
- R4: Bank b uses the bank-0 data addresses plus b × 0x1400, so bank 1 sits at 0x1400 (receive) and 0x1408 (set). A bank's latches are affected only by writes to that bank's own addresses.
- R5: Pad p's configuration word sits at 0x400 + 8·p and holds these fields:
  - bit 0: output enable
  - bit 1: invert
  - bit 12: open-drain
  - bits 25:16: function select, where 0 means owned by GPIO

  All other bits read back as 0.
- R6: Push-pull mode applies when the pad is GPIO-owned and open-drain is 0. Two clock edges after the write, `pad_oe` equals the output enable and `pad_out` equals the latch XOR invert.
- R7: Open-drain mode applies when the pad is GPIO-owned and open-drain is 1. `pad_out` is 0. `pad_oe` is 1 only when output enable is 1 and (latch XOR invert) is 0.
- R8: When the function select is nonzero, `pad_out` and `pad_oe` follow `alt_out` and `alt_oe` one edge later, whatever the latch and the other fields hold.
- R9: The receive register (bank 0 at 0x0) returns each pad input XOR that pad's invert bit. The input passes through a two-flop synchronizer first, so a new pad level is returned by a read whose address is presented two edges after the change.
- R10: The constant register at 0x90 returns the pad count in bits 7:0 and the base vector index in bits 15:8. All other bits are 0.
- R11: `bus_rdata` is registered and reflects the address presented before the previous clock edge. Unmapped addresses (for example 0x18) read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 64 | Write data |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_rdata | output | 64 | Registered read data |
| pad_in | input | NUM_PINS | Sampled pad levels |
| pad_out | output | NUM_PINS | Registered value driven toward each pad |
| pad_oe | output | NUM_PINS | Registered pad drive enable |
| alt_out | input | NUM_PINS | Output from the alternate function, used when the function select is nonzero |
| alt_oe | input | NUM_PINS | Drive enable from the alternate function |

## Verification
The hardest case to reach is an open-drain pad changing between driven-low and released. This requires a latch value, an invert bit and an open-drain configuration to be in place together, and each of them can be reached only through a separate write. The stimulus first sets latches with the set register and then programs the pad for open-drain, which leaves it released. It then drops the latch through the clear register and confirms that the pad becomes driven low. The receive path is checked twice: once for its synchronizer latency, by reading in the cycle right after a pad change and expecting the old level, and once for inversion on a pad whose invert bit is set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned WORD_W       = 64;
  localparam int unsigned FUNC_W       = 10;
  localparam int unsigned CFG_OE_BIT   = 0;
  localparam int unsigned CFG_INV_BIT  = 1;
  localparam int unsigned CFG_OD_BIT   = 12;
  localparam int unsigned CFG_FUNC_LSB = 16;

  typedef struct packed {
    logic [FUNC_W-1:0] func;
    logic              od;
    logic              inv;
    logic              oe;
  } pin_cfg_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX,
    SEL_SET,
    SEL_CLR,
    SEL_CONST,
    SEL_CFG
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] cfg_to_word(pin_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CFG_OE_BIT]  = c.oe;
    w[CFG_INV_BIT] = c.inv;
    w[CFG_OD_BIT]  = c.od;
    w[CFG_FUNC_LSB +: FUNC_W] = c.func;
    return w;
  endfunction

  function automatic pin_cfg_t word_to_cfg(logic [WORD_W-1:0] w);
    pin_cfg_t c;
    c.oe   = w[CFG_OE_BIT];
    c.inv  = w[CFG_INV_BIT];
    c.od   = w[CFG_OD_BIT];
    c.func = w[CFG_FUNC_LSB +: FUNC_W];
    return c;
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned NUM_BANKS   = 2,
  parameter int unsigned NUM_PINS    = 128,
  parameter int unsigned BANK_STRIDE = 'h1400,
  parameter int unsigned CFG_BASE    = 'h400,
  parameter int unsigned CONST_OFF   = 'h90,
  parameter int unsigned RX_OFF      = 'h0,
  parameter int unsigned SET_OFF     = 'h8,
  parameter int unsigned CLR_OFF     = 'h10,
  parameter int unsigned BANK_IDX_W  = 1,
  parameter int unsigned PIN_IDX_W   = 7
) (
  input  logic [ADDR_W-1:0]     addr,
  output reg_sel_e              sel,
  output logic [BANK_IDX_W-1:0] bank,
  output logic [PIN_IDX_W-1:0]  pin
);

  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + 8 * NUM_PINS);
  localparam logic [ADDR_W-1:0] CST_A  = ADDR_W'(CONST_OFF);

  logic [ADDR_W-1:0] cfg_off;
  assign cfg_off = addr - CFG_LO;
  assign pin     = cfg_off[PIN_IDX_W+2:3];

  always_comb begin
    sel  = SEL_NONE;
    bank = '0;
    if (addr == CST_A) begin
      sel = SEL_CONST;
    end else if ((addr >= CFG_LO) && (addr < CFG_HI) && (addr[2:0] == 3'b000)) begin
      sel = SEL_CFG;
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(b * BANK_STRIDE + RX_OFF)) begin
        sel  = SEL_RX;
        bank = BANK_IDX_W'(b);
      end else if (addr == ADDR_W'(b * BANK_STRIDE + SET_OFF)) begin
        sel  = SEL_SET;
        bank = BANK_IDX_W'(b);
      end else if (addr == ADDR_W'(b * BANK_STRIDE + CLR_OFF)) begin
        sel  = SEL_CLR;
        bank = BANK_IDX_W'(b);
      end
    end
  end

endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank #(
  parameter int unsigned BANK_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] latch
);

  logic [BANK_W-1:0] set_mask;
  logic [BANK_W-1:0] clr_mask;

  assign set_mask = set_we ? wdata : '0;
  assign clr_mask = clr_we ? wdata : '0;

  // Clear is applied after set, so a bit named by both ends low.
  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '0;
    end else begin
      latch <= (latch | set_mask) & ~clr_mask;
    end
  end

endmodule

// File: rtl/gpio_pin_pad.sv
module gpio_pin_pad
  import gpio_bank_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pin_cfg_t cfg,
  input  logic     latch_bit,
  input  logic     alt_out,
  input  logic     alt_oe,
  input  logic     pad_in,
  output logic     pad_out,
  output logic     pad_oe,
  output logic     rx_bit
);

  logic [1:0] sync_q;
  logic       eff;
  logic       gpio_own;
  logic       nxt_out;
  logic       nxt_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], pad_in};
    end
  end

  assign rx_bit   = sync_q[1] ^ cfg.inv;
  assign eff      = latch_bit ^ cfg.inv;
  assign gpio_own = (cfg.func == '0);

  always_comb begin
    if (!gpio_own) begin
      nxt_out = alt_out;
      nxt_oe  = alt_oe;
    end else if (cfg.od) begin
      nxt_out = 1'b0;
      nxt_oe  = cfg.oe & ~eff;
    end else begin
      nxt_out = eff;
      nxt_oe  = cfg.oe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
    end
  end

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 128,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned BANK_STRIDE = 'h1400,
  parameter int unsigned CFG_BASE    = 'h400,
  parameter int unsigned CONST_OFF   = 'h90,
  parameter logic [7:0]  VEC_BASE    = 8'd48
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [63:0]         bus_wdata,
  input  logic                bus_wr,
  output logic [63:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] alt_oe
);

  localparam int unsigned BANK_W     = WORD_W;
  localparam int unsigned NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int unsigned FLAT_W     = NUM_BANKS * BANK_W;
  localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned PIN_IDX_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [63:0] CONST_WORD = {48'd0, VEC_BASE, 8'(NUM_PINS)};

  reg_sel_e              sel;
  logic [BANK_IDX_W-1:0] bank_idx;
  logic [PIN_IDX_W-1:0]  pin_idx;

  logic [BANK_W-1:0] latch_bank [NUM_BANKS];
  logic [BANK_W-1:0] rx_bank    [NUM_BANKS];
  logic [FLAT_W-1:0] latch_flat;
  logic [FLAT_W-1:0] rx_flat;
  pin_cfg_t          cfg_q      [NUM_PINS];

  gpio_addr_dec #(
    .ADDR_W      (ADDR_W),
    .NUM_BANKS   (NUM_BANKS),
    .NUM_PINS    (NUM_PINS),
    .BANK_STRIDE (BANK_STRIDE),
    .CFG_BASE    (CFG_BASE),
    .CONST_OFF   (CONST_OFF),
    .BANK_IDX_W  (BANK_IDX_W),
    .PIN_IDX_W   (PIN_IDX_W)
  ) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .bank (bank_idx),
    .pin  (pin_idx)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic set_we;
    logic clr_we;
    assign set_we = bus_wr && (sel == SEL_SET) && (bank_idx == BANK_IDX_W'(b));
    assign clr_we = bus_wr && (sel == SEL_CLR) && (bank_idx == BANK_IDX_W'(b));

    gpio_out_bank #(.BANK_W(BANK_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .set_we (set_we),
      .clr_we (clr_we),
      .wdata  (bus_wdata),
      .latch  (latch_bank[b])
    );

    assign latch_flat[b*BANK_W +: BANK_W] = latch_bank[b];
    assign rx_bank[b] = rx_flat[b*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        cfg_q[p] <= '0;
      end
    end else if (bus_wr && (sel == SEL_CFG)) begin
      cfg_q[pin_idx] <= word_to_cfg(bus_wdata);
    end
  end

  for (genvar p = 0; p < FLAT_W; p++) begin : g_pin
    if (p < NUM_PINS) begin : g_live
      gpio_pin_pad u_pad (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_q[p]),
        .latch_bit (latch_flat[p]),
        .alt_out   (alt_out[p]),
        .alt_oe    (alt_oe[p]),
        .pad_in    (pad_in[p]),
        .pad_out   (pad_out[p]),
        .pad_oe    (pad_oe[p]),
        .rx_bit    (rx_flat[p])
      );
    end else begin : g_empty
      assign rx_flat[p] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (sel)
        SEL_RX:    bus_rdata <= rx_bank[bank_idx];
        SEL_SET:   bus_rdata <= latch_bank[bank_idx];
        SEL_CONST: bus_rdata <= CONST_WORD;
        SEL_CFG:   bus_rdata <= cfg_to_word(cfg_q[pin_idx]);
        default:   bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 128,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [7:0]  VEC_BASE = 8'd48
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [63:0]         bus_wdata,
  input logic [63:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] alt_oe,
  input logic [63:0]         bank0_latch,
  input pin_cfg_t            cfg [NUM_PINS]
);

  logic [NUM_PINS-1:0] od_own;
  logic [NUM_PINS-1:0] off_own;
  logic [NUM_PINS-1:0] alt_own;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      od_own[p]  = cfg[p].od && (cfg[p].func == '0);
      off_own[p] = !cfg[p].oe && (cfg[p].func == '0);
      alt_own[p] = (cfg[p].func != '0);
    end
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'('h8)) |=> ((bank0_latch & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'('h10)) |=> ((bank0_latch & $past(bus_wdata)) == 64'd0)); // R3

  AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & $past(off_own)) == '0)); // R6

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_out & $past(od_own)) == '0)); // R7

  AST_ALT_DRIVES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_oe ^ $past(alt_oe)) & $past(alt_own)) == '0)); // R8

  AST_CONST_WORD: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'('h90)) |=> (bus_rdata == {48'd0, VEC_BASE, 8'(NUM_PINS)})); // R10

  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'('h18)) |=> (bus_rdata == 64'd0)); // R11

endmodule

bind gpio_banked_ctrl gpio_banked_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .VEC_BASE (VEC_BASE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .alt_oe      (alt_oe),
  .bank0_latch (latch_bank[0]),
  .cfg         (cfg_q)
);

// File: tb/gpio_banked_ctrl_test.sv
`timescale 1ns/1ps
module gpio_banked_ctrl_test;

  localparam int NP = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   bus_addr = 16'h0018;
  logic [63:0]   bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic [63:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] alt_out = '0;
  logic [NP-1:0] alt_oe = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [63:0] exp_q [$];
  int          due_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  gpio_banked_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data as it appears against the scoreboard head.
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] == cyc) begin
      check(bus_rdata, exp_q[0], tag_q[0]);
      void'(exp_q.pop_front());
      void'(due_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 16'h0018;
  endtask

  task automatic rd(input logic [15:0] a, input logic [63:0] exp, input string tag);
    bus_addr = a;
    exp_q.push_back(exp);
    due_q.push_back(cyc + 1);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_addr = 16'h0018;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({64'd0, pad_oe}, '0, "R1 pad_oe after reset");
    check({64'd0, pad_out}, '0, "R1 pad_out after reset");
    rd(16'h0008, 64'd0, "R1 bank0 latches after reset");
    rd(16'h1408, 64'd0, "R1 bank1 latches after reset");
    rd(16'h0428, 64'd0, "R1 cfg pin5 after reset");

    rd(16'h0090, 64'h3080, "R10 constant word");
    rd(16'h0018, 64'd0, "R11 unmapped hole");

    wr(16'h0008, 64'hF0F0);
    rd(16'h0008, 64'hF0F0, "R2 set from zero");
    wr(16'h0008, 64'h000F);
    rd(16'h0008, 64'hF0FF, "R2 zero bits keep latches");
    wr(16'h0010, 64'h00F0);
    rd(16'h0008, 64'hF00F, "R3 clear selected bits");

    wr(16'h1408, 64'h8);
    rd(16'h1408, 64'h8, "R4 bank1 set");
    rd(16'h0008, 64'hF00F, "R4 bank0 untouched by bank1 write");

    wr(16'h0400, '1);
    rd(16'h0400, 64'h0000_0000_03FF_1003, "R5 cfg field readback");

    // pin0: latch 1, push-pull
    wr(16'h0400, 64'h1);
    settle();
    check({63'd0, pad_oe[0]}, 64'd1, "R6 pin0 driven");
    check({63'd0, pad_out[0]}, 64'd1, "R6 pin0 level");
    wr(16'h0400, 64'h3);
    settle();
    check({63'd0, pad_out[0]}, 64'd0, "R6 pin0 inverted level");

    // pin1: latch 1, open-drain -> released
    wr(16'h0408, 64'h1001);
    settle();
    check({62'd0, pad_oe[1], pad_out[1]}, 64'd0, "R7 od released when high");
    wr(16'h0010, 64'h2);
    settle();
    check({62'd0, pad_oe[1], pad_out[1]}, 64'd2, "R7 od drives low");

    // pin2: alternate function owns the pad
    alt_oe[2] = 1'b1; alt_out[2] = 1'b0;
    wr(16'h0410, 64'h0001_0001);
    settle();
    check({62'd0, pad_oe[2], pad_out[2]}, 64'd2, "R8 alt drives pad");
    alt_oe[2] = 1'b0;
    settle();
    check({63'd0, pad_oe[2]}, 64'd0, "R8 alt releases pad");

    // receive path
    pad_in = {64'h0123_4567_89AB_CDEF, 64'hA5A5_0000_1234_5679};
    settle();
    rd(16'h0000, 64'hA5A5_0000_1234_5678, "R9 rx bank0 with pin0 inverted");
    rd(16'h1400, 64'h0123_4567_89AB_CDEF, "R9 rx bank1");
    pad_in[63:0] = 64'd0;
    rd(16'h0000, 64'hA5A5_0000_1234_5678, "R9 synchronizer latency old value");
    settle();
    rd(16'h0000, 64'd1, "R9 new value after sync");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule